// File: doc/BRIEF.md
# Sampled-IF In-Phase/Quadrature Estimator

This block recovers the in-phase and quadrature components of an intermediate-frequency signal from ADC samples that are taken at a constant rate. The sample clock and the IF are chosen so that WIN_LEN samples cover exactly TURNS whole IF periods. Because of this, the sample phase advances by 2π·TURNS/WIN_LEN on each sample, and the pattern of phases repeats after every WIN_LEN samples. Each valid sample arrives together with a one-cycle strobe. The block multiplies the sample by a cosine coefficient and by a sine coefficient chosen for its phase slot. It adds the products into two running sums. After the last sample of a window it scales both sums by 2/WIN_LEN and presents signed I and Q words with a one-cycle ready pulse.

The 2/WIN_LEN scaling uses no divider. Each sum is shifted right, multiplied by the integer reciprocal floor(2^18/WIN_LEN), and shifted right again. The coefficient amplitude COEF_AMP = 2^13 is set so that a sinusoid of amplitude A and phase φ gives I = A·cos φ and Q = −A·sin φ. The block needs WIN_LEN ≥ 3, and WIN_LEN and TURNS must have no common factor.

Top module: `iqd_demod`

## Requirements
- R1: While reset is asserted and after it is released, i_o and q_o read 0 and iq_rdy_o is low. The phase slot returns to 0 and both sums are cleared.
- R2: The coefficient for slot k is round(COEF_AMP·cos(2π·TURNS·k/WIN_LEN)) on the I path and round(COEF_AMP·sin(2π·TURNS·k/WIN_LEN)) on the Q path. Slot 0 is the first sample after reset or after a completed window.
- R3: Each product (14-bit sample × 18-bit coefficient) is arithmetically shifted right by 8 and added to a 28-bit sum. The final sum is shifted right by 5, multiplied by floor(2^18/WIN_LEN) and shifted right by 17 to give the 14-bit result.
- R4: With WIN_LEN=4 and TURNS=9, a window of samples round(A·cos(2π·TURNS·k/WIN_LEN+φ)) gives i_o within 3 LSB of A·cos φ and q_o within 3 LSB of −A·sin φ.
- R5: The same accuracy holds for WIN_LEN=5, TURNS=2 and for WIN_LEN=8, TURNS=3.
- R6: A sample present while smp_vld_i is low has no effect on the phase slot or on either sum.
- R7: iq_rdy_o is high for exactly one cycle per window, at the second rising edge after the edge that captures the window's last strobed sample. New i_o and q_o are valid in that same cycle.
- R8: i_o and q_o keep their values in every cycle in which iq_rdy_o is low.
- R9: Windows may follow one another with strobes on consecutive cycles. Each window starts from zero sums at slot 0.
- R10: A reset in the middle of a window discards the partial sums, and the next window is estimated correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 14 | Signed ADC sample |
| smp_vld_i | input | 1 | Sample strobe, one cycle per sample |
| i_o | output | 14 | Signed in-phase estimate |
| q_o | output | 14 | Signed quadrature estimate |
| iq_rdy_o | output | 1 | One-cycle pulse when i_o/q_o are new |

## Verification
A slot counter that is out of step shows up as a rotated phase. The faulty I/Q pair appears at the first ready pulse, two cycles after that window's last sample. A sum that is not cleared corrupts the result of the next window. A fault in the strobe gating shows up either as a ready pulse with the wrong timing or as an estimate that is off by one sample's product. In both cases it is visible within one window. An error in the scaling chain shows as a fixed gain error, and every window reveals it.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // Rounded coefficient for slot k (cosine when sine_sel = 0, else sine).
  function automatic int coef_val(input int k, input int m, input int n,
                                  input int amp, input bit sine_sel);
    real ang;
    real v;
    ang = TWO_PI * real'(n) * real'(k) / real'(m);
    v   = sine_sel ? real'(amp) * $sin(ang) : real'(amp) * $cos(ang);
    if (v >= 0.0) coef_val = $rtoi(v + 0.5);
    else          coef_val = -$rtoi(-v + 0.5);
  endfunction
endpackage

// File: rtl/iqd_coef_rom.sv
module iqd_coef_rom #(
  parameter int WIN_LEN  = 4,
  parameter int TURNS    = 9,
  parameter int COEF_W   = 18,
  parameter int COEF_AMP = 8192,
  parameter int IDX_W    = $clog2(WIN_LEN)
) (
  input  logic [IDX_W-1:0]         idx_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  logic signed [COEF_W-1:0] cos_tab [WIN_LEN];
  logic signed [COEF_W-1:0] sin_tab [WIN_LEN];

  for (genvar k = 0; k < WIN_LEN; k++) begin : g_tab
    localparam int CV = iqd_pkg::coef_val(k, WIN_LEN, TURNS, COEF_AMP, 1'b0);
    localparam int SV = iqd_pkg::coef_val(k, WIN_LEN, TURNS, COEF_AMP, 1'b1);
    assign cos_tab[k] = COEF_W'(CV);
    assign sin_tab[k] = COEF_W'(SV);
  end

  always_comb begin
    cos_o = '0;
    sin_o = '0;
    for (int k = 0; k < WIN_LEN; k++) begin
      if (idx_i == IDX_W'(k)) begin
        cos_o = cos_tab[k];
        sin_o = sin_tab[k];
      end
    end
  end
endmodule

// File: rtl/iqd_accum.sv
module iqd_accum #(
  parameter int SAMPLE_W   = 14,
  parameter int COEF_W     = 18,
  parameter int PROD_SHIFT = 8,
  parameter int TERM_W     = 24,
  parameter int ACC_W      = 28
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic                       last_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic signed [COEF_W-1:0]   coef_i,
  output logic signed [ACC_W-1:0]    win_o
);
  localparam int PROD_W = SAMPLE_W + COEF_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_sh;
  logic signed [TERM_W-1:0] term;
  logic signed [ACC_W-1:0]  total;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic signed [ACC_W-1:0]  win_q, win_d;

  always_comb begin
    prod    = PROD_W'(smp_i) * PROD_W'(coef_i);
    prod_sh = prod >>> PROD_SHIFT;
    term    = prod_sh[TERM_W-1:0];
    total   = acc_q + ACC_W'(term);
    acc_d   = acc_q;
    win_d   = win_q;
    if (en_i) begin
      if (last_i) begin
        acc_d = '0;
        win_d = total;
      end else begin
        acc_d = total;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      win_q <= '0;
    end else begin
      acc_q <= acc_d;
      win_q <= win_d;
    end
  end

  assign win_o = win_q;

  // R9
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && last_i) |=> (acc_q == '0));

  // R6
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(acc_q) && $stable(win_q));
endmodule

// File: rtl/iqd_scale.sv
module iqd_scale #(
  parameter int ACC_W      = 28,
  parameter int ACC_SHIFT  = 5,
  parameter int RECIP_W    = 20,
  parameter int RECIP      = 65536,
  parameter int NORM_SHIFT = 17,
  parameter int OUT_W      = 14
) (
  input  logic signed [ACC_W-1:0] win_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam int MUL_W = ACC_W + RECIP_W;

  logic signed [ACC_W-1:0] red;
  logic signed [MUL_W-1:0] mul;
  logic signed [MUL_W-1:0] mul_sh;

  always_comb begin
    red    = win_i >>> ACC_SHIFT;
    mul    = MUL_W'(red) * MUL_W'(signed'(RECIP_W'(RECIP)));
    mul_sh = mul >>> NORM_SHIFT;
    res_o  = mul_sh[OUT_W-1:0];
  end
endmodule

// File: rtl/iqd_demod.sv
module iqd_demod #(
  parameter int WIN_LEN    = 4,
  parameter int TURNS      = 9,
  parameter int SAMPLE_W   = 14,
  parameter int COEF_W     = 18,
  parameter int COEF_AMP   = 8192,
  parameter int PROD_SHIFT = 8,
  parameter int ACC_W      = 28,
  parameter int ACC_SHIFT  = 5,
  parameter int NORM_SHIFT = 17,
  parameter int OUT_W      = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       smp_vld_i,
  output logic signed [OUT_W-1:0]    i_o,
  output logic signed [OUT_W-1:0]    q_o,
  output logic                       iq_rdy_o
);
  localparam int IDX_W   = $clog2(WIN_LEN);
  localparam int TERM_W  = SAMPLE_W + COEF_W - PROD_SHIFT;
  localparam int RECIP   = (1 << 18) / WIN_LEN;
  localparam int RECIP_W = 20;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

  logic [IDX_W-1:0]         idx_q, idx_d;
  logic                     last;
  logic                     win_vld_q, win_vld_d;
  logic signed [COEF_W-1:0] cos_c, sin_c;
  logic signed [ACC_W-1:0]  win_i, win_q;
  logic signed [OUT_W-1:0]  res_i, res_q;
  logic signed [OUT_W-1:0]  i_d, q_d;
  logic                     rdy_d;

  assign last = (idx_q == LAST_IDX);

  always_comb begin
    idx_d     = idx_q;
    win_vld_d = 1'b0;
    if (smp_vld_i) begin
      win_vld_d = last;
      idx_d     = last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      win_vld_q <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      win_vld_q <= win_vld_d;
    end
  end

  iqd_coef_rom #(
    .WIN_LEN(WIN_LEN), .TURNS(TURNS), .COEF_W(COEF_W),
    .COEF_AMP(COEF_AMP), .IDX_W(IDX_W)
  ) u_rom (
    .idx_i(idx_q), .cos_o(cos_c), .sin_o(sin_c)
  );

  iqd_accum #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .PROD_SHIFT(PROD_SHIFT),
    .TERM_W(TERM_W), .ACC_W(ACC_W)
  ) u_acc_i (
    .clk(clk), .rst_n(rst_n), .en_i(smp_vld_i), .last_i(last),
    .smp_i(smp_i), .coef_i(cos_c), .win_o(win_i)
  );

  iqd_accum #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .PROD_SHIFT(PROD_SHIFT),
    .TERM_W(TERM_W), .ACC_W(ACC_W)
  ) u_acc_q (
    .clk(clk), .rst_n(rst_n), .en_i(smp_vld_i), .last_i(last),
    .smp_i(smp_i), .coef_i(sin_c), .win_o(win_q)
  );

  iqd_scale #(
    .ACC_W(ACC_W), .ACC_SHIFT(ACC_SHIFT), .RECIP_W(RECIP_W),
    .RECIP(RECIP), .NORM_SHIFT(NORM_SHIFT), .OUT_W(OUT_W)
  ) u_scale_i (.win_i(win_i), .res_o(res_i));

  iqd_scale #(
    .ACC_W(ACC_W), .ACC_SHIFT(ACC_SHIFT), .RECIP_W(RECIP_W),
    .RECIP(RECIP), .NORM_SHIFT(NORM_SHIFT), .OUT_W(OUT_W)
  ) u_scale_q (.win_i(win_q), .res_o(res_q));

  always_comb begin
    i_d   = i_o;
    q_d   = q_o;
    rdy_d = win_vld_q;
    if (win_vld_q) begin
      i_d = res_i;
      q_d = res_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_o      <= '0;
      q_o      <= '0;
      iq_rdy_o <= 1'b0;
    end else begin
      i_o      <= i_d;
      q_o      <= q_d;
      iq_rdy_o <= rdy_d;
    end
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  // R6
  idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> $stable(idx_q));

  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_rdy_o |=> !iq_rdy_o);

  // R7
  rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && last) |=> ##1 iq_rdy_o);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iq_rdy_o |-> $stable(i_o) && $stable(q_o));
endmodule

// File: tb/iqd_demod_bench.sv
module iqd_demod_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 3;
  localparam int TOL = 3;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [13:0] smp [NDUT];
  logic stb [NDUT];
  logic signed [13:0] io [NDUT];
  logic signed [13:0] qo [NDUT];
  logic rdy [NDUT];

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int qi [NDUT][$];
  int qq [NDUT][$];
  int qc [NDUT][$];
  int qr [NDUT][$];
  logic signed [13:0] prev_i [NDUT];
  logic signed [13:0] prev_q [NDUT];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iqd_demod #(.WIN_LEN(4), .TURNS(9)) u_iqd_demod (
    .clk(clk), .rst_n(rst_n), .smp_i(smp[0]), .smp_vld_i(stb[0]),
    .i_o(io[0]), .q_o(qo[0]), .iq_rdy_o(rdy[0]));
  iqd_demod #(.WIN_LEN(5), .TURNS(2)) u_iqd_demod_m5 (
    .clk(clk), .rst_n(rst_n), .smp_i(smp[1]), .smp_vld_i(stb[1]),
    .i_o(io[1]), .q_o(qo[1]), .iq_rdy_o(rdy[1]));
  iqd_demod #(.WIN_LEN(8), .TURNS(3)) u_iqd_demod_m8 (
    .clk(clk), .rst_n(rst_n), .smp_i(smp[2]), .smp_vld_i(stb[2]),
    .i_o(io[2]), .q_o(qo[2]), .iq_rdy_o(rdy[2]));

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one window; gap>0 inserts idle cycles carrying junk samples.
  task automatic drive_win(input int d, input int m, input int n,
                           input real a, input real phi, input int gap,
                           input int req);
    for (int k = 0; k < m; k++) begin
      @(posedge clk); #1;
      stb[d] = 1'b1;
      smp[d] = 14'(rnd(a * $cos(TWO_PI * n * k / m + phi)));
      if (k == m - 1) begin
        qi[d].push_back(rnd(a * $cos(phi)));
        qq[d].push_back(rnd(-a * $sin(phi)));
        qc[d].push_back(cyc + 2);
        qr[d].push_back(req);
      end
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        stb[d] = 1'b0;
        smp[d] = 14'sd5000;
      end
    end
    @(posedge clk); #1;
    stb[d] = 1'b0;
    smp[d] = -14'sd3000;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < NDUT; d++) begin
        if (rdy[d]) begin
          if (qi[d].size() == 0) begin
            chk(1'b0, "R7 unexpected ready", 1, 0);
          end else begin
            int ei, eq, ec, rq;
            string tag;
            ei = qi[d].pop_front(); eq = qq[d].pop_front();
            ec = qc[d].pop_front(); rq = qr[d].pop_front();
            tag = $sformatf("R%0d", rq);
            chk(io[d] >= ei - TOL && io[d] <= ei + TOL, {tag, " I"}, io[d], ei);
            chk(qo[d] >= eq - TOL && qo[d] <= eq + TOL, {tag, " Q"}, qo[d], eq);
            chk(cyc == ec, "R7 latency", cyc, ec);
          end
        end else begin
          chk(io[d] == prev_i[d] && qo[d] == prev_q[d], "R8 hold", io[d], prev_i[d]);
        end
        prev_i[d] = io[d];
        prev_q[d] = qo[d];
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int d = 0; d < NDUT; d++) begin
      stb[d] = 1'b0; smp[d] = '0; prev_i[d] = '0; prev_q[d] = '0;
    end
    repeat (3) @(posedge clk);
    // R1: reset state
    for (int d = 0; d < NDUT; d++) begin
      chk(io[d] == 0 && qo[d] == 0, "R1 outputs", io[d], 0);
      chk(rdy[d] == 1'b0, "R1 ready", rdy[d], 0);
    end
    #1 rst_n = 1'b1;
    // R4 / R2 / R3: M=4, N=9 various phases
    drive_win(0, 4, 9, 5000.0, 0.0, 0, 4);
    drive_win(0, 4, 9, 3000.0, 1.0, 0, 2);
    drive_win(0, 4, 9, 7000.0, -2.5, 0, 3);
    drive_win(0, 4, 9, 8000.0, 3.0, 0, 4);
    // R6: gaps with junk samples
    drive_win(0, 4, 9, 4000.0, 0.7, 2, 6);
    // R9: back-to-back windows (no idle between)
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge clk); #1;
        stb[0] = 1'b1;
        smp[0] = 14'(rnd(2500.0 * (w + 1) * $cos(TWO_PI * 9 * k / 4 + 0.3 * w)));
        if (k == 3) begin
          qi[0].push_back(rnd(2500.0 * (w + 1) * $cos(0.3 * w)));
          qq[0].push_back(rnd(-2500.0 * (w + 1) * $sin(0.3 * w)));
          qc[0].push_back(cyc + 2);
          qr[0].push_back(9);
        end
      end
    end
    @(posedge clk); #1 stb[0] = 1'b0;
    // R5: other ratios
    drive_win(1, 5, 2, 6000.0, 0.4, 0, 5);
    drive_win(1, 5, 2, 3500.0, -1.9, 1, 5);
    drive_win(2, 8, 3, 6500.0, 2.2, 0, 5);
    drive_win(2, 8, 3, 1200.0, -0.8, 1, 5);
    repeat (4) @(posedge clk);
    // R10: partial window, reset, then full window
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1; stb[0] = 1'b1; smp[0] = 14'sd7000;
    end
    @(posedge clk); #1; stb[0] = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(io[0] == 0 && rdy[0] == 1'b0, "R1 reset clears outputs", io[0], 0);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int d = 0; d < NDUT; d++) begin prev_i[d] = '0; prev_q[d] = '0; end
    drive_win(0, 4, 9, 5500.0, 1.3, 0, 10);
    repeat (5) @(posedge clk);
    for (int d = 0; d < NDUT; d++)
      chk(qi[d].size() == 0, "R7 all windows reported", qi[d].size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule